// File: doc/BRIEF.md
# Watermark-Gated Burst FIFO Master

This block sits in an FPGA and drives a synchronous 32-bit parallel FIFO port on a USB bridge device. It owns the bus strobes and moves data only in fixed bursts of 256 words. Write bursts carry data from a local source FIFO toward the host. Read bursts pull host data into a local sink FIFO. The bridge's status flags are not guaranteed to meet the FPGA's setup or hold window, so every flag passes through a synchronizer before the controller uses it.

Each direction has a watermark flag. A burst may only start when that flag, after synchronization, reads high. High means the bridge can absorb or supply a complete burst without stalling. The controller commits to the whole burst once it starts, and any flag movement during the burst is ignored. After each burst it idles for a guard interval that covers the synchronizer delay and the bridge's own flag update time. Only then does it look at the flags again.

A flag fault in the bridge is handled by a startup rule. After reset, or after a reconnect pulse, no burst starts until the host-to-device ready flag has been seen high. When both directions are eligible at the same time, the controller alternates between them.

Top module: `wm_burst_master`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, the outputs `bus_cs_n`, `bus_wr_n`, `bus_rd_n` and `bus_oe_n` are all 1, and `src_pop` and `snk_push` are 0.
- R2: Every burst holds exactly one of `bus_wr_n` or `bus_rd_n` low for exactly BURST_LEN (256) consecutive cycles. `bus_cs_n` is low for exactly those cycles. `bus_addr` is 0 during a write burst and 3 during a read burst.
- R3: Each raw flag goes through a two-flop synchronizer. Suppose a raw watermark flag rises in cycle c while the controller is idle, armed and otherwise eligible. Then the burst strobe is still high in cycles c, c+1 and c+2, and goes low in cycle c+3.
- R4: A write burst starts only when the synchronized write watermark flag is 1 and `src_level` is at least BURST_LEN. A read burst starts only when the synchronized read watermark flag is 1. While a flag is 0, no burst starts in its direction.
- R5: After reset, no burst of either direction starts until the synchronized ready flag (`rdy_raw`) has been 1 at least once.
- R6: Once a burst has started, it runs to its full length even if its watermark flag falls during the burst.
- R7: Between the last strobe cycle of one burst and the first strobe cycle of the next, at least GUARD_CYC (4) cycles pass with all strobes high.
- R8: For each read-strobe cycle t, `snk_push` is 1 in cycle t+RD_LAT (RD_LAT is 2) with `snk_data` equal to `bus_din` in that cycle. `snk_push` is 1 in no other cycle, so each read burst yields exactly BURST_LEN pushes.
- R9: In every write-burst cycle, `bus_dout` equals `src_data` and `src_pop` is 1. `src_pop` is 0 in every other cycle.
- R10: When both directions are eligible at each decision point, consecutive bursts alternate direction.
- R11: A one-cycle `reconnect` pulse clears the armed state. No new burst starts until the synchronized ready flag is seen high again. A burst already running completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reconnect | input | 1 | One-cycle pulse that re-arms the startup ready-flag wait |
| wm_wr_raw | input | 1 | Unsynchronized write-direction watermark flag; 1 allows a write burst |
| wm_rd_raw | input | 1 | Unsynchronized read-direction watermark flag; 1 allows a read burst |
| rdy_raw | input | 1 | Unsynchronized host-to-device ready flag used for arming |
| bus_cs_n | output | 1 | Bridge chip select, active low |
| bus_wr_n | output | 1 | Bridge write strobe, active low |
| bus_rd_n | output | 1 | Bridge read strobe, active low |
| bus_oe_n | output | 1 | Bridge output enable, active low during read bursts |
| bus_addr | output | 2 | Bridge FIFO select: 0 for write, 3 for read |
| bus_dout | output | 32 | Write data toward the bridge |
| bus_din | input | 32 | Read data from the bridge |
| src_level | input | 11 | Words held in the local source FIFO |
| src_data | input | 32 | Head word of the local source FIFO |
| src_pop | output | 1 | Source FIFO advance |
| snk_push | output | 1 | Sink FIFO write enable |
| snk_data | output | 32 | Sink FIFO write data |

## Verification
The bench raises a watermark flag in a known idle cycle and checks the exact cycle in which the strobe falls. A controller that skips a synchronizer stage, or adds one, starts the burst one cycle off and fails. It drops the write watermark in the middle of a write burst, which exposes a design that aborts or shortens the burst. It also lowers the source level below one burst, which exposes a design that would start a write that must stall. It holds both directions eligible for many bursts to catch a stuck priority, and it pulses reconnect with the ready flag low to catch a design whose arming is set only once after reset.

// File: rtl/wmb_pkg.sv
package wmb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_READ  = 2'd2,
        ST_GUARD = 2'd3
    } wmb_state_e;

    localparam int FLG_WM_WR = 0;
    localparam int FLG_WM_RD = 1;
    localparam int FLG_RDY   = 2;
    localparam int FLG_NUM   = 3;
endpackage

// File: rtl/wmb_flag_sync.sv
module wmb_flag_sync #(
    parameter int NUM    = 3,
    parameter int STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NUM-1:0] raw_i,
    output logic [NUM-1:0] sync_o
);
    generate
        for (genvar g = 0; g < NUM; g++) begin : g_flag
            logic [STAGES-1:0] chain_d, chain_q;

            if (STAGES == 1) begin : g_one
                always_comb chain_d = raw_i[g];
            end else begin : g_many
                always_comb chain_d = {chain_q[STAGES-2:0], raw_i[g]};
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= chain_d;
            end

            assign sync_o[g] = chain_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/wmb_rd_capture.sv
module wmb_rd_capture #(
    parameter int DATA_W = 32,
    parameter int RD_LAT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_i,
    input  logic [DATA_W-1:0] bus_din_i,
    output logic              push_o,
    output logic [DATA_W-1:0] data_o
);
    logic [RD_LAT-1:0] vld_d, vld_q;

    generate
        if (RD_LAT == 1) begin : g_lat1
            always_comb vld_d = strobe_i;
        end else begin : g_latn
            always_comb vld_d = {vld_q[RD_LAT-2:0], strobe_i};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vld_q <= '0;
        else        vld_q <= vld_d;
    end

    assign push_o = vld_q[RD_LAT-1];
    assign data_o = bus_din_i;
endmodule

// File: rtl/wmb_burst_fsm.sv
module wmb_burst_fsm
    import wmb_pkg::*;
#(
    parameter int BURST_LEN = 256,
    parameter int GUARD_CYC = 4,
    parameter int LVL_W     = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reconnect_i,
    input  logic             wm_wr_i,
    input  logic             wm_rd_i,
    input  logic             rdy_i,
    input  logic [LVL_W-1:0] src_level_i,
    output logic             wr_act_o,
    output logic             rd_act_o
);
    localparam int SPAN  = (BURST_LEN > GUARD_CYC) ? BURST_LEN : GUARD_CYC;
    localparam int CNT_W = (SPAN > 1) ? $clog2(SPAN) : 1;
    localparam logic [CNT_W-1:0] LAST_BEAT  = CNT_W'(BURST_LEN - 1);
    localparam logic [CNT_W-1:0] LAST_GUARD = CNT_W'(GUARD_CYC - 1);
    localparam logic [LVL_W-1:0] NEED_LVL   = LVL_W'(BURST_LEN);

    typedef struct packed {
        wmb_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic             armed;
        logic             last_wr;
    } fsm_t;

    fsm_t ctl_d, ctl_q;
    logic wr_go, rd_go;

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.armed = reconnect_i ? 1'b0 : (ctl_q.armed | rdy_i);
        wr_go = ctl_q.armed & wm_wr_i & (src_level_i >= NEED_LVL);
        rd_go = ctl_q.armed & wm_rd_i;

        unique case (ctl_q.st)
            ST_IDLE: begin
                if (wr_go && (!rd_go || !ctl_q.last_wr)) begin
                    ctl_d.st      = ST_WRITE;
                    ctl_d.cnt     = '0;
                    ctl_d.last_wr = 1'b1;
                end else if (rd_go) begin
                    ctl_d.st      = ST_READ;
                    ctl_d.cnt     = '0;
                    ctl_d.last_wr = 1'b0;
                end
            end
            ST_WRITE, ST_READ: begin
                if (ctl_q.cnt == LAST_BEAT) begin
                    ctl_d.st  = ST_GUARD;
                    ctl_d.cnt = '0;
                end else begin
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                end
            end
            ST_GUARD: begin
                if (ctl_q.cnt == LAST_GUARD) begin
                    ctl_d.st  = ST_IDLE;
                    ctl_d.cnt = '0;
                end else begin
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.st      <= ST_IDLE;
            ctl_q.cnt     <= '0;
            ctl_q.armed   <= 1'b0;
            ctl_q.last_wr <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign wr_act_o = (ctl_q.st == ST_WRITE);
    assign rd_act_o = (ctl_q.st == ST_READ);
endmodule

// File: rtl/wm_burst_master.sv
module wm_burst_master
    import wmb_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 2,
    parameter int LVL_W       = 11,
    parameter int BURST_LEN   = 256,
    parameter int GUARD_CYC   = 4,
    parameter int RD_LAT      = 2,
    parameter int SYNC_STAGES = 2,
    parameter int WR_ADDR     = 0,
    parameter int RD_ADDR     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reconnect,
    input  logic              wm_wr_raw,
    input  logic              wm_rd_raw,
    input  logic              rdy_raw,
    output logic              bus_cs_n,
    output logic              bus_wr_n,
    output logic              bus_rd_n,
    output logic              bus_oe_n,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_dout,
    input  logic [DATA_W-1:0] bus_din,
    input  logic [LVL_W-1:0]  src_level,
    input  logic [DATA_W-1:0] src_data,
    output logic              src_pop,
    output logic              snk_push,
    output logic [DATA_W-1:0] snk_data
);
    logic [FLG_NUM-1:0] flg_raw, flg_s;
    logic wr_act, rd_act;

    always_comb begin
        flg_raw            = '0;
        flg_raw[FLG_WM_WR] = wm_wr_raw;
        flg_raw[FLG_WM_RD] = wm_rd_raw;
        flg_raw[FLG_RDY]   = rdy_raw;
    end

    wmb_flag_sync #(.NUM(FLG_NUM), .STAGES(SYNC_STAGES)) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (flg_raw),
        .sync_o (flg_s)
    );

    wmb_burst_fsm #(.BURST_LEN(BURST_LEN), .GUARD_CYC(GUARD_CYC), .LVL_W(LVL_W)) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .reconnect_i (reconnect),
        .wm_wr_i     (flg_s[FLG_WM_WR]),
        .wm_rd_i     (flg_s[FLG_WM_RD]),
        .rdy_i       (flg_s[FLG_RDY]),
        .src_level_i (src_level),
        .wr_act_o    (wr_act),
        .rd_act_o    (rd_act)
    );

    wmb_rd_capture #(.DATA_W(DATA_W), .RD_LAT(RD_LAT)) cap_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe_i  (rd_act),
        .bus_din_i (bus_din),
        .push_o    (snk_push),
        .data_o    (snk_data)
    );

    assign bus_cs_n = ~(wr_act | rd_act);
    assign bus_wr_n = ~wr_act;
    assign bus_rd_n = ~rd_act;
    assign bus_oe_n = ~rd_act;
    assign bus_addr = rd_act ? ADDR_W'(RD_ADDR) : ADDR_W'(WR_ADDR);
    assign bus_dout = src_data;
    assign src_pop  = wr_act;
endmodule

// File: rtl/wmb_checker.sv
module wmb_checker #(
    parameter int LVL_W     = 11,
    parameter int BURST_LEN = 256,
    parameter int GUARD_CYC = 4,
    parameter int RD_LAT    = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reconnect,
    input logic             rdy_raw,
    input logic             bus_cs_n,
    input logic             bus_wr_n,
    input logic             bus_rd_n,
    input logic [LVL_W-1:0] src_level,
    input logic             src_pop,
    input logic             snk_push
);
    localparam int RUN_W = $clog2(BURST_LEN + 2) + 1;
    localparam int GAP_W = $clog2(GUARD_CYC + 2) + 1;

    logic [RUN_W-1:0] run_q;
    logic [GAP_W-1:0] gap_q;
    logic [3:0]       rdy_hist_q;
    logic             seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q      <= '0;
            gap_q      <= GAP_W'(GUARD_CYC);
            rdy_hist_q <= '0;
            seen_q     <= 1'b0;
        end else begin
            run_q      <= bus_cs_n ? '0 : run_q + 1'b1;
            if (!bus_cs_n)                      gap_q <= '0;
            else if (gap_q < GAP_W'(GUARD_CYC)) gap_q <= gap_q + 1'b1;
            rdy_hist_q <= {rdy_hist_q[2:0], rdy_raw};
            seen_q     <= reconnect ? 1'b0 : (seen_q | rdy_raw | (|rdy_hist_q));
        end
    end

    // R2: never both strobes, chip select covers each strobe, exact length
    a_r2_one_dir: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_wr_n && !bus_rd_n));
    a_r2_cs_cover: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr_n || !bus_rd_n) |-> !bus_cs_n);
    a_r2_burst_len: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_cs_n) |-> (run_q == RUN_W'(BURST_LEN)));
    // R4: write burst only with a full burst in the source
    a_r4_src_level: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_wr_n) |-> ($past(src_level) >= LVL_W'(BURST_LEN)));
    // R5 / R11: no start before the ready flag was seen since reset or reconnect
    a_r5_armed: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_cs_n) |-> (seen_q || $past(reconnect)));
    // R7: guard gap between bursts
    a_r7_guard: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_cs_n) |-> (gap_q >= GAP_W'(GUARD_CYC)));
    // R8: push only a fixed latency after a read strobe
    a_r8_push_lat: assert property (@(posedge clk) disable iff (!rst_n)
        snk_push |-> $past(!bus_rd_n, RD_LAT));
    // R9: pop tracks the write strobe
    a_r9_pop: assert property (@(posedge clk) disable iff (!rst_n)
        src_pop |-> !bus_wr_n);
endmodule

bind wm_burst_master wmb_checker #(
    .LVL_W(LVL_W), .BURST_LEN(BURST_LEN), .GUARD_CYC(GUARD_CYC), .RD_LAT(RD_LAT)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reconnect (reconnect),
    .rdy_raw   (rdy_raw),
    .bus_cs_n  (bus_cs_n),
    .bus_wr_n  (bus_wr_n),
    .bus_rd_n  (bus_rd_n),
    .src_level (src_level),
    .src_pop   (src_pop),
    .snk_push  (snk_push)
);

// File: tb/wm_burst_master_tb_top.sv
module wm_burst_master_tb_top;
    localparam int BL = 256;
    localparam int GC = 4;
    localparam int RL = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reconnect = 1'b0;
    logic        wm_wr_raw = 1'b0, wm_rd_raw = 1'b0, rdy_raw = 1'b0;
    logic        bus_cs_n, bus_wr_n, bus_rd_n, bus_oe_n;
    logic [1:0]  bus_addr;
    logic [31:0] bus_dout, snk_data;
    logic [31:0] bus_din = '0;
    logic [10:0] src_level = '0;
    logic [31:0] src_data = '0;
    logic        src_pop, snk_push;

    always #5 clk = ~clk;

    wm_burst_master dut_i (
        .clk(clk), .rst_n(rst_n), .reconnect(reconnect),
        .wm_wr_raw(wm_wr_raw), .wm_rd_raw(wm_rd_raw), .rdy_raw(rdy_raw),
        .bus_cs_n(bus_cs_n), .bus_wr_n(bus_wr_n), .bus_rd_n(bus_rd_n),
        .bus_oe_n(bus_oe_n), .bus_addr(bus_addr), .bus_dout(bus_dout),
        .bus_din(bus_din), .src_level(src_level), .src_data(src_data),
        .src_pop(src_pop), .snk_push(snk_push), .snk_data(snk_data)
    );

    // stimulus controls
    bit f_rst = 1, f_wr = 0, f_rd = 0, f_rdy = 0, f_rec = 0, keep_full = 0;
    int unsigned src_q[$];
    int unsigned next_src = 32'h1000;
    int unsigned rd_word = 32'hC0000000;
    int unsigned snk_expect = 32'hC0000000;
    bit rd_hist[$];
    int errors = 0, checks = 0, cyc = 0;
    bit done = 0;

    // reference model state
    bit ms1[3], ms2[3];
    bit m_arm, m_lastwr;
    int m_st, m_cnt;
    logic [RL-1:0] m_rdv;

    // burst monitor
    bit prev_act = 0;
    int run_len = 0, gap = 1000, n_wr = 0, n_rd = 0;
    int dirs[$];

    task automatic check(bit ok, string tag, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    task automatic one_cycle();
        bit exp_wr, exp_rd, exp_push, wr_go, rd_go, act;
        bit raw[3];
        @(posedge clk);
        #1;
        rst_n = !f_rst;
        reconnect = f_rec;
        wm_wr_raw = f_wr; wm_rd_raw = f_rd; rdy_raw = f_rdy;
        if (keep_full) while (src_q.size() < 600) begin src_q.push_back(next_src); next_src++; end
        src_level = 11'(src_q.size());
        src_data = (src_q.size() > 0) ? src_q[0] : 32'h0;
        if (rd_hist.size() == RL && rd_hist[0]) begin bus_din = rd_word; rd_word++; end
        else bus_din = 32'h5A5A0000 ^ cyc;
        #3;
        exp_wr = (m_st == 1); exp_rd = (m_st == 2); exp_push = m_rdv[RL-1];
        // R2: strobes, chip select, address
        check({bus_cs_n, bus_wr_n, bus_rd_n, bus_oe_n, bus_addr} ==
              {!(exp_wr || exp_rd), !exp_wr, !exp_rd, !exp_rd, exp_rd ? 2'd3 : 2'd0},
              "R2", "strobes/addr", {bus_cs_n, bus_wr_n, bus_rd_n, bus_oe_n, bus_addr},
              {!(exp_wr || exp_rd), !exp_wr, !exp_rd, !exp_rd, exp_rd ? 2'd3 : 2'd0});
        // R9: write data and pop
        check(src_pop == exp_wr && (!exp_wr || bus_dout == src_data), "R9", "pop/dout",
              {src_pop, bus_dout}, {exp_wr, src_data});
        // R8: push timing and data order
        check(snk_push == exp_push, "R8", "snk_push", snk_push, exp_push);
        if (exp_push) begin
            check(snk_data == snk_expect, "R8", "snk_data", snk_data, snk_expect);
            snk_expect++;
        end
        // monitor burst runs
        act = !bus_wr_n || !bus_rd_n;
        if (rst_n) begin
            if (act && !prev_act) begin
                if (n_wr + n_rd > 0) check(gap >= GC, "R7", "guard gap", gap, GC);
                dirs.push_back(!bus_wr_n ? 1 : 2);
                if (!bus_wr_n) n_wr++; else n_rd++;
                run_len = 0;
            end
            if (!act && prev_act) check(run_len == BL, "R2", "burst length", run_len, BL);
            if (act) begin run_len++; gap = 0; end else gap++;
            prev_act = act;
        end
        // model advance to next edge
        if (!rst_n) begin
            ms1 = '{0, 0, 0}; ms2 = '{0, 0, 0}; m_arm = 0; m_lastwr = 0;
            m_st = 0; m_cnt = 0; m_rdv = '0;
        end else begin
            raw = '{wm_wr_raw, wm_rd_raw, rdy_raw};
            wr_go = m_arm && ms2[0] && (src_level >= BL);
            rd_go = m_arm && ms2[1];
            m_arm = reconnect ? 1'b0 : (m_arm | ms2[2]);
            case (m_st)
                0: if (wr_go && (!rd_go || !m_lastwr)) begin m_st = 1; m_cnt = 0; m_lastwr = 1; end
                   else if (rd_go) begin m_st = 2; m_cnt = 0; m_lastwr = 0; end
                1, 2: if (m_cnt == BL - 1) begin m_st = 3; m_cnt = 0; end else m_cnt++;
                default: if (m_cnt == GC - 1) begin m_st = 0; m_cnt = 0; end else m_cnt++;
            endcase
            m_rdv = (m_rdv << 1) | RL'(exp_rd);
            ms2 = ms1; ms1 = raw;
        end
        if (src_pop === 1'b1 && src_q.size() > 0) void'(src_q.pop_front());
        rd_hist.push_back(!bus_rd_n);
        if (rd_hist.size() > RL) void'(rd_hist.pop_front());
        cyc++;
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) one_cycle();
    endtask

    task automatic fill(int n);
        for (int i = 0; i < n; i++) begin src_q.push_back(next_src); next_src++; end
    endtask

    initial begin
        int base, wr0, rd0, k;
        // R1: reset state
        run(4);
        check({bus_cs_n, bus_wr_n, bus_rd_n, bus_oe_n, src_pop, snk_push} == 6'b111100,
              "R1", "reset outputs", {bus_cs_n, bus_wr_n, bus_rd_n, bus_oe_n, src_pop, snk_push}, 6'b111100);
        f_rst = 0;
        run(1);
        check({bus_cs_n, bus_wr_n, bus_rd_n, src_pop, snk_push} == 5'b11100,
              "R1", "first cycle after reset", {bus_cs_n, bus_wr_n, bus_rd_n, src_pop, snk_push}, 5'b11100);
        // R5: eligible flags but ready never seen
        fill(300); f_wr = 1; f_rd = 1;
        run(60);
        check(n_wr + n_rd == 0, "R5", "bursts before ready", n_wr + n_rd, 0);
        // arm with both watermarks low
        f_wr = 0; f_rd = 0; f_rdy = 1;
        run(12);
        check(n_wr + n_rd == 0, "R4", "bursts with watermarks low", n_wr + n_rd, 0);
        // R3: synchronizer latency
        f_wr = 1;
        for (int i = 0; i < 3; i++) begin
            run(1);
            check(bus_wr_n == 1'b1, "R3", "strobe before sync latency", bus_wr_n, 1);
        end
        run(1);
        check(bus_wr_n == 1'b0, "R3", "strobe after sync latency", bus_wr_n, 0);
        run(300);
        // R10: both eligible, alternation
        keep_full = 1; f_rd = 1;
        base = dirs.size();
        run(2200);
        check(dirs.size() - base >= 6, "R10", "bursts in alternation window", dirs.size() - base, 6);
        for (int i = base + 1; i < dirs.size(); i++)
            check(dirs[i] != dirs[i-1], "R10", "direction alternates", dirs[i], 3 - dirs[i-1]);
        // R6: write flag falls mid-burst
        k = 0;
        while (bus_wr_n && k < 1000) begin run(1); k++; end
        check(bus_wr_n == 1'b0, "R6", "write burst found", bus_wr_n, 0);
        run(10); f_wr = 0;
        wr0 = n_wr; rd0 = n_rd;
        run(260);
        check(run_len == BL || dirs[dirs.size()-1] == 2, "R6", "burst completed", run_len, BL);
        run(800);
        check(n_wr == wr0, "R4", "no write while flag low", n_wr, wr0);
        check(n_rd > rd0, "R4", "reads continue", n_rd, rd0 + 1);
        // R4: source below one burst
        f_rd = 0; keep_full = 0;
        run(300);
        src_q.delete(); fill(100); f_wr = 1;
        wr0 = n_wr;
        run(300);
        check(n_wr == wr0, "R4", "no write with short source", n_wr, wr0);
        fill(200);
        run(12);
        check(n_wr == wr0 + 1, "R4", "write once source is full", n_wr, wr0 + 1);
        run(300);
        // R11: reconnect re-arms the ready wait
        f_rdy = 0;
        run(6);
        f_rec = 1; run(1); f_rec = 0;
        keep_full = 1; f_wr = 1; f_rd = 1;
        wr0 = n_wr; rd0 = n_rd;
        run(200);
        check(n_wr + n_rd == wr0 + rd0, "R11", "no burst after reconnect", n_wr + n_rd, wr0 + rd0);
        f_rdy = 1;
        run(20);
        check(n_wr + n_rd > wr0 + rd0, "R11", "burst after ready again", n_wr + n_rd, wr0 + rd0 + 1);
        run(600);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(1_500_000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule